// File: doc/BRIEF.md
# Load Element Width Converter

This block turns one raw memory read of up to 64 bits into a register element value. Each request carries the data, an access size code, two endianness controls, a source element size, a destination element size and saturation controls. The block works in one fixed order. It keeps only the bytes of the access size. It then reverses their order if required. Next it resizes the value to the source element size, and last it narrows or widens the value to the destination element size. That final step either keeps the low bits or clamps the value to the signed or unsigned range of the destination.

There is one registered stage. A request presented with `in_valid` appears on the outputs one clock later, with `out_valid` set. The result is zero-filled above the destination element size on a 64-bit bus. A separate flag reports size combinations whose meaning is not defined: a source element narrower than the access, and, for store traffic, a destination element narrower than the access. Placing the element into a register file is left to the surrounding logic.

Top module: `elem_ld_conv`

## Requirements
- R1: An accepted request (`in_valid`=1 at a rising edge) produces its result with `out_valid`=1 after exactly one clock. When `in_valid` is 0, `out_valid` falls to 0 at the next edge and `out_data`/`out_undef` keep their previous values.
- R2: Size codes on `in_opw`, `in_srcw` and `in_dstw` are 0=8, 1=16, 2=32 and 3=64 bits. Only the low 8<<`in_opw` bits of `in_data` take part in the result.
- R3: The access-size bytes are reversed (byte 0 swapped with the top byte of the access, and so on) exactly when `in_brev` equals `in_le`. Otherwise they pass in order.
- R4: With `in_sat`=0, the value is zero-extended or truncated to the source size, and then zero-extended or truncated to the destination size.
- R5: With `in_sat`=1, the value is sign-extended from its access-size top bit, or truncated, to the source size. It is then treated as a signed number of the source size.
- R6: With `in_sat`=1 and `in_sgn`=1, values above the signed destination maximum become that maximum (e.g. 0x7F for 8 bits). Values below the minimum become the minimum (0x80 for 8 bits). In-range values pass unchanged.
- R7: With `in_sat`=1 and `in_sgn`=0, negative values become 0, values above the destination all-ones value become all-ones, and others pass unchanged.
- R8: `out_undef` is 1 when the source size is smaller than the access size, or when `in_store`=1 and the destination size is smaller than the access size. Otherwise it is 0. The data result is still produced.
- R9: `out_data` bits at and above the destination size are always 0.
- R10: While `rst_n` is low, `out_valid`, `out_data` and `out_undef` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_data | input | 64 | Raw memory read, access bytes in the low end |
| in_opw | input | 2 | Access size code |
| in_brev | input | 1 | Byte-reversed access variant |
| in_le | input | 1 | Little-endian mode bit |
| in_srcw | input | 2 | Source element size code |
| in_dstw | input | 2 | Destination element size code |
| in_sat | input | 1 | Saturating narrowing enable |
| in_sgn | input | 1 | Signed (1) or unsigned (0) saturation |
| in_store | input | 1 | Request belongs to a store; enables the destination-size check |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Converted element, zero above destination size |
| out_undef | output | 1 | Undefined size combination |

## Verification
The hardest cases to reach are those where the clamp decision depends on a sign bit that comes from a truncation rather than from the raw data. One example is a 32-bit access cut to a 16-bit source whose new top bit is set. Another is a negative 32-bit access that is sign-extended to 64 bits and then clamped by unsigned saturation. The vector table sets each case up with data patterns whose sign bit sits exactly at the access or source boundary. Each swap case pairs the two flag settings that reverse with one setting that does not, so both outcomes of the XNOR are seen.

// File: rtl/elc_pkg.sv
package elc_pkg;

  localparam int unsigned ELC_XLEN = 64;

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } elw_e;

  // all-ones over the bits of a size code
  function automatic logic [ELC_XLEN-1:0] ew_mask(input logic [1:0] code);
    logic [ELC_XLEN-1:0] m;
    case (code)
      2'd0:    m = {{(ELC_XLEN-8){1'b0}},  {8{1'b1}}};
      2'd1:    m = {{(ELC_XLEN-16){1'b0}}, {16{1'b1}}};
      2'd2:    m = {{(ELC_XLEN-32){1'b0}}, {32{1'b1}}};
      default: m = {ELC_XLEN{1'b1}};
    endcase
    return m;
  endfunction

  // top bit of a value of the given size
  function automatic logic ew_msb(input logic [ELC_XLEN-1:0] v, input logic [1:0] code);
    logic b;
    case (code)
      2'd0:    b = v[7];
      2'd1:    b = v[15];
      2'd2:    b = v[31];
      default: b = v[ELC_XLEN-1];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/elc_byteswap.sv
module elc_byteswap
  import elc_pkg::*;
#(
  parameter int unsigned XLEN = ELC_XLEN
) (
  input  logic [XLEN-1:0] din,
  input  logic [1:0]      opw,
  input  logic            swap,
  output logic [XLEN-1:0] dout
);
  localparam int unsigned NBYTES = XLEN / 8;
  localparam int unsigned NCODES = 4;

  logic [XLEN-1:0] rev [NCODES];

  for (genvar w = 0; w < NCODES; w++) begin : g_size
    localparam int unsigned NB = 1 << w;
    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
      if (i < NB) begin : g_in
        assign rev[w][i*8 +: 8] = din[(NB-1-i)*8 +: 8];
      end else begin : g_out
        assign rev[w][i*8 +: 8] = 8'h00;
      end
    end
  end

  always_comb begin
    if (swap) dout = rev[opw];
    else      dout = din & ew_mask(opw);
  end

endmodule

// File: rtl/elc_src_adjust.sv
module elc_src_adjust
  import elc_pkg::*;
#(
  parameter int unsigned XLEN = ELC_XLEN
) (
  input  logic [XLEN-1:0] op_val,   // zero above access size
  input  logic [1:0]      opw,
  input  logic [1:0]      srcw,
  input  logic            sat,
  output logic [XLEN-1:0] src_val,  // zero above source size
  output logic [XLEN-1:0] src_sx    // source value sign-extended to XLEN
);
  logic [XLEN-1:0] widened;

  always_comb begin
    widened = op_val;
    if (sat && ew_msb(op_val, opw)) widened = op_val | ~ew_mask(opw);
    src_val = widened & ew_mask(srcw);
    src_sx  = src_val;
    if (ew_msb(src_val, srcw)) src_sx = src_val | ~ew_mask(srcw);
  end

endmodule

// File: rtl/elc_dst_narrow.sv
module elc_dst_narrow
  import elc_pkg::*;
#(
  parameter int unsigned XLEN = ELC_XLEN
) (
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] src_sx,
  input  logic [1:0]      dstw,
  input  logic            sat,
  input  logic            sgn,
  output logic [XLEN-1:0] dst_val
);
  logic [XLEN-1:0] dmask;
  logic [XLEN-1:0] smax;
  logic [XLEN-1:0] smin;

  always_comb begin
    dmask = ew_mask(dstw);
    smax  = dmask >> 1;
    smin  = ~smax;
    if (!sat) begin
      dst_val = src_val & dmask;
    end else if (sgn) begin
      if ($signed(src_sx) > $signed(smax))      dst_val = smax;
      else if ($signed(src_sx) < $signed(smin)) dst_val = smin & dmask;
      else                                      dst_val = src_sx & dmask;
    end else begin
      if (src_sx[XLEN-1])      dst_val = '0;
      else if (src_sx > dmask) dst_val = dmask;
      else                     dst_val = src_sx;
    end
  end

endmodule

// File: rtl/elem_ld_conv.sv
module elem_ld_conv
  import elc_pkg::*;
#(
  parameter int unsigned XLEN = ELC_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] in_data,
  input  logic [1:0]      in_opw,
  input  logic            in_brev,
  input  logic            in_le,
  input  logic [1:0]      in_srcw,
  input  logic [1:0]      in_dstw,
  input  logic            in_sat,
  input  logic            in_sgn,
  input  logic            in_store,
  output logic            out_valid,
  output logic [XLEN-1:0] out_data,
  output logic            out_undef
);
  logic            swap;
  logic [XLEN-1:0] op_val;
  logic [XLEN-1:0] src_val;
  logic [XLEN-1:0] src_sx;
  logic [XLEN-1:0] dst_val;
  logic            undef_d;

  logic            valid_q, valid_n;
  logic [XLEN-1:0] data_q,  data_n;
  logic            undef_q, undef_n;

  assign swap = ~(in_brev ^ in_le);

  elc_byteswap #(.XLEN(XLEN)) u_swap (
    .din  (in_data),
    .opw  (in_opw),
    .swap (swap),
    .dout (op_val)
  );

  elc_src_adjust #(.XLEN(XLEN)) u_src (
    .op_val  (op_val),
    .opw     (in_opw),
    .srcw    (in_srcw),
    .sat     (in_sat),
    .src_val (src_val),
    .src_sx  (src_sx)
  );

  elc_dst_narrow #(.XLEN(XLEN)) u_dst (
    .src_val (src_val),
    .src_sx  (src_sx),
    .dstw    (in_dstw),
    .sat     (in_sat),
    .sgn     (in_sgn),
    .dst_val (dst_val)
  );

  assign undef_d = (in_srcw < in_opw) | (in_store & (in_dstw < in_opw));

  // next state with explicit enable
  always_comb begin
    valid_n = in_valid;
    data_n  = data_q;
    undef_n = undef_q;
    if (in_valid) begin
      data_n  = dst_val;
      undef_n = undef_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      undef_q <= 1'b0;
    end else begin
      valid_q <= valid_n;
      data_q  <= data_n;
      undef_q <= undef_n;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_undef = undef_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_undef))); // R1
  AST_ZERO_ABOVE_DST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_data & ~ew_mask($past(in_dstw))) == '0)); // R9
  AST_UNDEF_NARROW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_srcw < in_opw)) |=> out_undef); // R8
  AST_USAT_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sat && !in_sgn && src_sx[XLEN-1]) |=> (out_data == '0)); // R7
  AST_SSAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sat && in_sgn && !src_sx[XLEN-1] && (in_dstw != 2'd3)) |=>
      (ew_msb(out_data, $past(in_dstw)) == 1'b0)); // R6
  AST_PLAIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sat && !swap && (in_opw <= in_srcw) && (in_opw <= in_dstw)) |=>
      (out_data == ($past(in_data) & ew_mask($past(in_opw))))); // R4

endmodule

// File: tb/tb_elem_ld_conv.sv
module tb_elem_ld_conv;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 21;

  typedef struct packed {
    logic [63:0] d;
    logic [1:0]  op;
    logic        br;
    logic        le;
    logic [1:0]  sw;
    logic [1:0]  dw;
    logic        sat;
    logic        sg;
    logic        st;
    logic [63:0] exp;
    logic        eu;
    logic [7:0]  req;
  } vec_t;

  // d, op, brev, le, srcw, dstw, sat, sgn, store, expected, undef, requirement
  localparam vec_t VEC [NVEC] = '{
    '{64'h1122334455667788, 2'd0, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 64'h88, 1'b0, 8'd2},               // R2
    '{64'h1122334455667788, 2'd1, 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 64'h7788, 1'b0, 8'd2},             // R2
    '{64'h1122334455667788, 2'd2, 1'b0, 1'b1, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0, 64'h88, 1'b0, 8'd9},               // R9
    '{64'h1122334455667788, 2'd2, 1'b0, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 64'h88776655, 1'b0, 8'd3},         // R3
    '{64'h1122334455667788, 2'd3, 1'b1, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 64'h8877665544332211, 1'b0, 8'd3}, // R3
    '{64'h1122334455667788, 2'd1, 1'b1, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 64'h7788, 1'b0, 8'd3},             // R3
    '{64'h00000000000000F0, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 64'h00F0, 1'b0, 8'd4},             // R4
    '{64'h00000000000000F0, 2'd0, 1'b0, 1'b1, 2'd1, 2'd1, 1'b1, 1'b1, 1'b0, 64'hFFF0, 1'b0, 8'd5},             // R5
    '{64'h0000000000001234, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 64'h7F, 1'b0, 8'd6},               // R6
    '{64'h0000000000008000, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 64'h80, 1'b0, 8'd6},               // R6
    '{64'h000000000000FFFE, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 64'hFE, 1'b0, 8'd6},               // R6
    '{64'h000000000000FFFE, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 64'h00, 1'b0, 8'd7},               // R7
    '{64'h0000000000000123, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 64'hFF, 1'b0, 8'd7},               // R7
    '{64'h00000000000000C8, 2'd1, 1'b0, 1'b1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 64'hC8, 1'b0, 8'd7},               // R7
    '{64'h1122334455667788, 2'd2, 1'b0, 1'b1, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 64'h7788, 1'b1, 8'd8},             // R8
    '{64'h1122334455667788, 2'd2, 1'b0, 1'b1, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 64'h7788, 1'b1, 8'd8},             // R8
    '{64'h1122334455667788, 2'd2, 1'b0, 1'b1, 2'd3, 2'd1, 1'b0, 1'b0, 1'b0, 64'h7788, 1'b0, 8'd8},             // R8
    '{64'h0000000000018000, 2'd2, 1'b0, 1'b1, 2'd1, 2'd3, 1'b1, 1'b1, 1'b0, 64'hFFFFFFFFFFFF8000, 1'b1, 8'd5}, // R5
    '{64'h8000000000000000, 2'd3, 1'b0, 1'b1, 2'd3, 2'd3, 1'b1, 1'b1, 1'b0, 64'h8000000000000000, 1'b0, 8'd6}, // R6
    '{64'h0000000080000000, 2'd2, 1'b0, 1'b1, 2'd3, 2'd3, 1'b1, 1'b0, 1'b0, 64'h0, 1'b0, 8'd7},                // R7
    '{64'h0000000100000000, 2'd3, 1'b0, 1'b1, 2'd3, 2'd2, 1'b1, 1'b1, 1'b0, 64'h7FFFFFFF, 1'b0, 8'd6}          // R6
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_data;
  logic [1:0]  in_opw;
  logic        in_brev;
  logic        in_le;
  logic [1:0]  in_srcw;
  logic [1:0]  in_dstw;
  logic        in_sat;
  logic        in_sgn;
  logic        in_store;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_undef;

  int checks;
  int errors;

  elem_ld_conv dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_opw(in_opw), .in_brev(in_brev), .in_le(in_le), .in_srcw(in_srcw),
    .in_dstw(in_dstw), .in_sat(in_sat), .in_sgn(in_sgn), .in_store(in_store),
    .out_valid(out_valid), .out_data(out_data), .out_undef(out_undef)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; in_data = v.d; in_opw = v.op; in_brev = v.br; in_le = v.le;
    in_srcw = v.sw; in_dstw = v.dw; in_sat = v.sat; in_sgn = v.sg; in_store = v.st;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_opw = '0; in_brev = 1'b0;
    in_le = 1'b1; in_srcw = '0; in_dstw = '0; in_sat = 1'b0; in_sgn = 1'b0; in_store = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", {63'd0, out_valid}, 64'd0);
    check("R10 data", out_data, 64'd0);
    check("R10 undef", {63'd0, out_undef}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k]);
      @(negedge clk);
      check($sformatf("R%0d vec%0d data", VEC[k].req, k), out_data, VEC[k].exp);
      check($sformatf("R%0d vec%0d undef", VEC[k].req, k), {63'd0, out_undef}, {63'd0, VEC[k].eu});
      check($sformatf("R1 vec%0d valid", k), {63'd0, out_valid}, 64'd1);
    end

    // R1: idle cycle holds data and drops valid, even with new inputs present
    in_valid = 1'b0; in_data = 64'hFFFF_FFFF_FFFF_FFFF; in_dstw = 2'd3; in_srcw = 2'd0; in_opw = 2'd3;
    @(negedge clk);
    check("R1 idle valid", {63'd0, out_valid}, 64'd0);
    check("R1 idle hold data", out_data, 64'h7FFFFFFF);
    check("R1 idle hold undef", {63'd0, out_undef}, 64'd0);

    // R1: back-to-back requests each land one cycle later
    drive(VEC[0]);
    @(negedge clk);
    check("R1 b2b first", out_data, 64'h88);
    drive(VEC[3]);
    @(negedge clk);
    check("R1 b2b second", out_data, 64'h88776655);
    in_valid = 1'b0;

    // R10: reset in mid-run clears outputs
    rst_n = 1'b0;
    #1;
    check("R10 async data", out_data, 64'd0);
    check("R10 async valid", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule